// File: doc/BRIEF.md
# Short-Burst Radio Packet Framer

This block turns one payload into the serial bit sequence of a short radio burst. A frame holds, in this order: a one-byte preamble, the receiver address (3, 4 or 5 bytes), an optional 9-bit control word, 1 to 32 payload bytes, and an optional CRC of one or two bytes. Each field goes out most significant bit first. The address starts with its most significant used byte. The first address bit sets the preamble polarity, so the alternating preamble runs straight into the address.

A frame starts with a one-cycle `start_i` pulse. On that edge the framer captures every configuration input, so later changes to those inputs do not touch the frame in progress. Payload bytes come in over a valid/ready port. The framer holds one byte in reserve and fetches ahead, beginning as soon as the frame starts. Bits leave over a valid/ready port. `tx_ready_i` is the bit-enable tick from the modulator, and one bit is consumed on each cycle where `tx_valid_o` and `tx_ready_i` are both high.

Back-pressure works as follows. A bit stays on `tx_bit_o` until it is taken. If the next payload byte has not arrived when the previous field ends, `tx_valid_o` drops until the byte comes in. No bit is repeated or lost, and ticks during the gap are ignored. A 2-bit packet identifier moves forward on every new payload and is reused on a retransmission.

Top module: `pkt_framer`

## Requirements
- R1: `start_i` is accepted only while no frame is active, the length is 1..32 and the address width is 3..5 bytes. `frame_active_o` rises on the cycle after acceptance. A start that breaks any of these conditions, or that arrives while a frame is active, is ignored and leaves the packet identifier unchanged.
- R2: The first 8 bits of a frame are 10101010 when the first address bit (bit 8*width-1 of `addr_i`) is 1, and 01010101 when it is 0.
- R3: The address follows the preamble as bits 8*width-1 down to 0 of `addr_i`, most significant first.
- R4: When the dynamic-length or auto-ack enable is set, a 9-bit control word follows the address: length (6 bits), then packet identifier (2 bits), then no-ack (1 bit), each most significant first. When both enables are clear, the payload follows the address directly.
- R5: The packet identifier resets to 0. Each accepted start with `retx_i`=0 sends the previous value plus 1, modulo 4. An accepted start with `retx_i`=1 sends the previous value unchanged.
- R6: The framer accepts exactly `pay_len_i` payload bytes over the valid/ready port, with `pl_ready_o` low outside a frame, and sends them in arrival order, each most significant bit first.
- R7: The 1-byte CRC uses polynomial x^8+x^2+x+1 (0x07) with initial value 0xFF, shifted MSB first over the address, control and payload bits. It is sent MSB first, with no final inversion.
- R8: The 2-byte CRC uses polynomial x^16+x^12+x^5+1 (0x1021) with initial value 0xFFFF, over the same bits, in the same manner.
- R9: A CRC is appended when the CRC enable, the dynamic-length enable or the auto-ack enable is set. Its length is 2 bytes when `crc_two_i` is 1 and 1 byte otherwise.
- R10: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_bit_o` and `tx_valid_o` hold. During a payload underrun `tx_valid_o` is low and the bit stream later resumes intact.
- R11: `frame_active_o` falls on the cycle after the last bit is taken. The bit count is 8 + 8*width + (9 if control) + 8*length + CRC bits. Configuration changes after acceptance do not alter the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a frame (one-cycle pulse) |
| retx_i | input | 1 | 1: resend with the current packet identifier |
| addr_i | input | 40 | Receiver address, right-aligned |
| addr_bytes_i | input | 3 | Address width in bytes (3..5) |
| pay_len_i | input | 6 | Payload length in bytes (1..32) |
| no_ack_i | input | 1 | No-ack flag placed in the control word |
| crc_en_i | input | 1 | CRC enable |
| crc_two_i | input | 1 | 1: 2-byte CRC, 0: 1-byte CRC |
| dyn_len_i | input | 1 | Dynamic-length enable (adds control word, forces CRC) |
| auto_ack_i | input | 1 | Auto-ack enable (adds control word, forces CRC) |
| pl_valid_i | input | 1 | Payload byte valid |
| pl_data_i | input | 8 | Payload byte |
| pl_ready_o | output | 1 | Framer can take a payload byte |
| tx_ready_i | input | 1 | Bit-enable tick from the modulator |
| tx_valid_o | output | 1 | `tx_bit_o` holds a bit to send |
| tx_bit_o | output | 1 | Serial bit |
| frame_active_o | output | 1 | A frame is in progress |

## Verification
The hardest state to reach from the ports is a payload underrun in the middle of a frame, where the output has to pause without disturbing the CRC or losing a bit. The bench reaches it by pacing the payload source with a long gap between bytes while ticking every other cycle. It then confirms that `tx_valid_o` dropped and that the received stream still matches bit for bit. A second hard case is a start pulse plus configuration changes during a frame. The bench applies them a few cycles after acceptance and shows, through the bits of that frame and the identifier of the next one, that neither had any effect. A receive-side CRC checker in the bench runs over each captured frame, CRC included, and expects a zero remainder for both CRC sizes.

// File: rtl/pkt_framer_pkg.sv
package pkt_framer_pkg;
  typedef enum logic [2:0] {
    FS_IDLE,
    FS_PRE,
    FS_ADDR,
    FS_CTRL,
    FS_PAY,
    FS_CRC
  } fr_state_e;

  localparam logic [7:0] PRE_ONE_FIRST  = 8'hAA;
  localparam logic [7:0] PRE_ZERO_FIRST = 8'h55;
  localparam int unsigned CTRL_BITS     = 9;
endpackage

// File: rtl/pkt_crc_lane.sv
module pkt_crc_lane #(
  parameter int unsigned     W    = 8,
  parameter logic [W-1:0]    POLY = 8'h07,
  parameter logic [W-1:0]    INIT = 8'hFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] crc_nxt_o
);
  logic [W-1:0] crc_q;
  logic         fb;

  always_comb begin
    fb        = crc_q[W-1] ^ bit_i;
    crc_nxt_o = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       crc_q <= INIT;
    else if (clear_i) crc_q <= INIT;
    else if (en_i)    crc_q <= crc_nxt_o;
  end
endmodule

// File: rtl/pkt_pid_gen.sv
module pkt_pid_gen #(
  parameter int unsigned PID_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance_i,
  output logic [PID_W-1:0] pid_o,
  output logic [PID_W-1:0] pid_nxt_o
);
  logic [PID_W-1:0] pid_q;

  assign pid_o     = pid_q;
  assign pid_nxt_o = pid_q + PID_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pid_q <= '0;
    else if (advance_i) pid_q <= pid_nxt_o;
  end
endmodule

// File: rtl/pkt_pay_stage.sv
module pkt_pay_stage #(
  parameter int unsigned DW    = 8,
  parameter int unsigned LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             active_i,
  input  logic             in_valid_i,
  input  logic [DW-1:0]    in_data_i,
  output logic             in_ready_o,
  input  logic             take_i,
  output logic             have_o,
  output logic [DW-1:0]    byte_o
);
  logic [LEN_W-1:0] want_q;
  logic [LEN_W-1:0] got_q;
  logic             full_q;
  logic [DW-1:0]    hold_q;

  assign in_ready_o = active_i && !full_q && (got_q != want_q);
  assign have_o     = full_q;
  assign byte_o     = hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_q <= '0;
      got_q  <= '0;
      full_q <= 1'b0;
      hold_q <= '0;
    end else if (arm_i) begin
      want_q <= len_i;
      got_q  <= '0;
      full_q <= 1'b0;
    end else begin
      if (in_valid_i && in_ready_o) begin
        hold_q <= in_data_i;
        full_q <= 1'b1;
        got_q  <= got_q + LEN_W'(1);
      end else if (take_i) begin
        full_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pkt_framer.sv
module pkt_framer
  import pkt_framer_pkg::*;
#(
  parameter int unsigned ADDR_MIN_BYTES = 3,
  parameter int unsigned ADDR_MAX_BYTES = 5,
  parameter int unsigned PAY_MAX        = 32,
  parameter int unsigned LEN_W          = 6,
  parameter int unsigned PID_W          = 2
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  start_i,
  input  logic                                  retx_i,
  input  logic [8*ADDR_MAX_BYTES-1:0]           addr_i,
  input  logic [$clog2(ADDR_MAX_BYTES+1)-1:0]   addr_bytes_i,
  input  logic [LEN_W-1:0]                      pay_len_i,
  input  logic                                  no_ack_i,
  input  logic                                  crc_en_i,
  input  logic                                  crc_two_i,
  input  logic                                  dyn_len_i,
  input  logic                                  auto_ack_i,
  input  logic                                  pl_valid_i,
  input  logic [7:0]                            pl_data_i,
  output logic                                  pl_ready_o,
  input  logic                                  tx_ready_i,
  output logic                                  tx_valid_o,
  output logic                                  tx_bit_o,
  output logic                                  frame_active_o
);
  localparam int unsigned SH_W  = 8 * ADDR_MAX_BYTES;
  localparam int unsigned CNT_W = $clog2(SH_W + 1);
  localparam int unsigned AW_W  = $clog2(ADDR_MAX_BYTES + 1);
  localparam int unsigned CW    = LEN_W + PID_W + 1;

  fr_state_e          state_q;
  logic [SH_W-1:0]    sh_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [LEN_W-1:0]   left_q;
  logic               starve_q;
  logic [SH_W-1:0]    addr_q;
  logic [AW_W-1:0]    aw_q;
  logic [CW-1:0]      ctrl_q;
  logic               ctrl_on_q, crc_on_q, crc_two_q;

  logic               len_ok, aw_ok, accept;
  logic [SH_W-1:0]    addr_al;
  logic               xfer, last_bit, crc_en_w, next_is_pay, take;
  logic [PID_W-1:0]   pid_cur, pid_nxt;
  logic               have_byte;
  logic [7:0]         pay_byte;
  logic [7:0]         crc8_nxt;
  logic [15:0]        crc16_nxt;

  // Input qualification and capture
  assign len_ok = (pay_len_i >= LEN_W'(1)) && (pay_len_i <= LEN_W'(PAY_MAX));
  assign aw_ok  = (addr_bytes_i >= AW_W'(ADDR_MIN_BYTES)) &&
                  (addr_bytes_i <= AW_W'(ADDR_MAX_BYTES));
  assign accept = start_i && (state_q == FS_IDLE) && len_ok && aw_ok;

  always_comb begin
    addr_al = addr_i << (8 * (ADDR_MAX_BYTES - int'(addr_bytes_i)));
  end

  // Output side
  assign frame_active_o = (state_q != FS_IDLE);
  assign tx_valid_o     = frame_active_o && !starve_q;
  assign tx_bit_o       = sh_q[SH_W-1];
  assign xfer           = tx_valid_o && tx_ready_i;
  assign last_bit       = xfer && (cnt_q == CNT_W'(1));
  assign crc_en_w       = xfer && ((state_q == FS_ADDR) || (state_q == FS_CTRL) ||
                                   (state_q == FS_PAY));

  always_comb begin
    next_is_pay = 1'b0;
    if (last_bit) begin
      unique case (state_q)
        FS_ADDR: next_is_pay = !ctrl_on_q;
        FS_CTRL: next_is_pay = 1'b1;
        FS_PAY:  next_is_pay = (left_q > LEN_W'(1));
        default: next_is_pay = 1'b0;
      endcase
    end
  end

  assign take = have_byte && (starve_q || next_is_pay);

  pkt_pid_gen #(.PID_W(PID_W)) u_pid (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance_i(accept && !retx_i),
    .pid_o    (pid_cur),
    .pid_nxt_o(pid_nxt)
  );

  pkt_pay_stage #(.DW(8), .LEN_W(LEN_W)) u_pay (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_i     (accept),
    .len_i     (pay_len_i),
    .active_i  (frame_active_o),
    .in_valid_i(pl_valid_i),
    .in_data_i (pl_data_i),
    .in_ready_o(pl_ready_o),
    .take_i    (take),
    .have_o    (have_byte),
    .byte_o    (pay_byte)
  );

  pkt_crc_lane #(.W(8), .POLY(8'h07), .INIT(8'hFF)) u_crc8 (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (accept),
    .en_i     (crc_en_w),
    .bit_i    (tx_bit_o),
    .crc_nxt_o(crc8_nxt)
  );

  pkt_crc_lane #(.W(16), .POLY(16'h1021), .INIT(16'hFFFF)) u_crc16 (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (accept),
    .en_i     (crc_en_w),
    .bit_i    (tx_bit_o),
    .crc_nxt_o(crc16_nxt)
  );

  // Field sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= FS_IDLE;
      sh_q      <= '0;
      cnt_q     <= '0;
      left_q    <= '0;
      starve_q  <= 1'b0;
      addr_q    <= '0;
      aw_q      <= '0;
      ctrl_q    <= '0;
      ctrl_on_q <= 1'b0;
      crc_on_q  <= 1'b0;
      crc_two_q <= 1'b0;
    end else if (accept) begin
      state_q   <= FS_PRE;
      sh_q      <= {(addr_al[SH_W-1] ? PRE_ONE_FIRST : PRE_ZERO_FIRST), {(SH_W-8){1'b0}}};
      cnt_q     <= CNT_W'(8);
      left_q    <= pay_len_i;
      starve_q  <= 1'b0;
      addr_q    <= addr_al;
      aw_q      <= addr_bytes_i;
      ctrl_q    <= {pay_len_i, (retx_i ? pid_cur : pid_nxt), no_ack_i};
      ctrl_on_q <= dyn_len_i || auto_ack_i;
      crc_on_q  <= crc_en_i || dyn_len_i || auto_ack_i;
      crc_two_q <= crc_two_i;
    end else if (starve_q) begin
      if (have_byte) begin
        sh_q     <= {pay_byte, {(SH_W-8){1'b0}}};
        cnt_q    <= CNT_W'(8);
        starve_q <= 1'b0;
      end
    end else if (xfer) begin
      if (!last_bit) begin
        sh_q  <= sh_q << 1;
        cnt_q <= cnt_q - CNT_W'(1);
      end else if (next_is_pay) begin
        state_q <= FS_PAY;
        if (state_q == FS_PAY) left_q <= left_q - LEN_W'(1);
        if (have_byte) begin
          sh_q  <= {pay_byte, {(SH_W-8){1'b0}}};
          cnt_q <= CNT_W'(8);
        end else begin
          starve_q <= 1'b1;
        end
      end else begin
        unique case (state_q)
          FS_PRE: begin
            state_q <= FS_ADDR;
            sh_q    <= addr_q;
            cnt_q   <= CNT_W'(8 * int'(aw_q));
          end
          FS_ADDR: begin
            state_q <= FS_CTRL;
            sh_q    <= {ctrl_q, {(SH_W-CW){1'b0}}};
            cnt_q   <= CNT_W'(CW);
          end
          FS_PAY: begin
            if (crc_on_q) begin
              state_q <= FS_CRC;
              if (crc_two_q) begin
                sh_q  <= {crc16_nxt, {(SH_W-16){1'b0}}};
                cnt_q <= CNT_W'(16);
              end else begin
                sh_q  <= {crc8_nxt, {(SH_W-8){1'b0}}};
                cnt_q <= CNT_W'(8);
              end
            end else begin
              state_q <= FS_IDLE;
            end
          end
          default: state_q <= FS_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/pkt_framer_chk.sv
module pkt_framer_chk #(
  parameter int unsigned ADDR_MIN_BYTES = 3,
  parameter int unsigned ADDR_MAX_BYTES = 5,
  parameter int unsigned PAY_MAX        = 32,
  parameter int unsigned LEN_W          = 6,
  parameter int unsigned PID_W          = 2
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                start_i,
  input logic [8*ADDR_MAX_BYTES-1:0]         addr_i,
  input logic [$clog2(ADDR_MAX_BYTES+1)-1:0] addr_bytes_i,
  input logic                                pl_ready_o,
  input logic                                tx_ready_i,
  input logic                                tx_valid_o,
  input logic                                tx_bit_o,
  input logic                                frame_active_o
);
  logic first_addr_bit;
  always_comb begin
    first_addr_bit = 1'b0;
    for (int i = ADDR_MIN_BYTES; i <= ADDR_MAX_BYTES; i++)
      if (int'(addr_bytes_i) == i) first_addr_bit = addr_i[8*i-1];
  end

  // R1
  start_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_active_o) |-> $past(start_i));

  // R2
  preamble_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_active_o) |-> (tx_bit_o == $past(first_addr_bit)));

  // R6
  pl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_active_o |-> !pl_ready_o);

  // R10
  held_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_bit_o)));

  // R11
  end_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_active_o) |-> $past(tx_valid_o && tx_ready_i));
endmodule

bind pkt_framer pkt_framer_chk #(
  .ADDR_MIN_BYTES(ADDR_MIN_BYTES),
  .ADDR_MAX_BYTES(ADDR_MAX_BYTES),
  .PAY_MAX       (PAY_MAX),
  .LEN_W         (LEN_W),
  .PID_W         (PID_W)
) u_chk (.*);

// File: tb/tb_pkt_framer.sv
module tb_pkt_framer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, retx = 1'b0;
  logic [39:0] addr = '0;
  logic [2:0]  aw = 3'd5;
  logic [5:0]  len = 6'd1;
  logic        no_ack = 1'b0, crc_en = 1'b0, crc_two = 1'b0, dyn = 1'b0, aa = 1'b0;
  logic        pl_valid = 1'b0;
  logic [7:0]  pl_data = '0;
  logic        pl_ready;
  logic        tx_ready = 1'b0;
  logic        tx_valid, tx_bit, frame_active;

  int checks = 0, errors = 0;
  int exp_pid = 0;
  bit done = 1'b0;
  logic [7:0] pay_mem [0:31];
  bit exp_b [0:511];
  bit got_b [0:511];
  int exp_n, got_n;

  always #2 clk = ~clk;

  pkt_framer dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .retx_i(retx), .addr_i(addr),
    .addr_bytes_i(aw), .pay_len_i(len), .no_ack_i(no_ack), .crc_en_i(crc_en),
    .crc_two_i(crc_two), .dyn_len_i(dyn), .auto_ack_i(aa), .pl_valid_i(pl_valid),
    .pl_data_i(pl_data), .pl_ready_o(pl_ready), .tx_ready_i(tx_ready),
    .tx_valid_o(tx_valid), .tx_bit_o(tx_bit), .frame_active_o(frame_active)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [39:0] v, input int nb);
    for (int i = nb - 1; i >= 0; i--) begin
      exp_b[exp_n] = v[i];
      exp_n++;
    end
  endtask

  function automatic logic [15:0] crc_run(input bit two, input bit use_got,
                                          input int from, input int upto);
    logic [15:0] c = two ? 16'hFFFF : 16'h00FF;
    for (int i = from; i < upto; i++) begin
      bit b = use_got ? got_b[i] : exp_b[i];
      if (two) c = {c[14:0], 1'b0} ^ ((c[15] ^ b) ? 16'h1021 : 16'h0000);
      else     c = {8'h00, c[6:0], 1'b0} ^ ((c[7] ^ b) ? 16'h0007 : 16'h0000);
    end
    return c;
  endfunction

  task automatic run_frame(input logic [39:0] a, input int awb, input int ln,
                           input bit na, input bit ce, input bit c2, input bit dy,
                           input bit au, input bit rx, input int gap, input int tper,
                           input bit disturb, input string name);
    int addr_end, ctrl_end, pay_end, src_idx, gapc, tickc, cycles;
    bit ctrl_on, crc_on, starved, pl_x;
    logic [15:0] c;
    for (int i = 0; i < 32; i++) pay_mem[i] = 8'((i * 37) + (ln * 11) + 8'h5A);
    if (!rx) exp_pid = (exp_pid + 1) % 4;
    ctrl_on = dy || au;
    crc_on  = ce || dy || au;
    exp_n = 0;
    push(a[8*awb-1] ? 40'hAA : 40'h55, 8);
    push(a, 8 * awb);
    addr_end = exp_n;
    if (ctrl_on) push(40'({6'(ln), 2'(exp_pid), na}), 9);
    ctrl_end = exp_n;
    for (int i = 0; i < ln; i++) push(40'(pay_mem[i]), 8);
    pay_end = exp_n;
    if (crc_on) begin
      c = crc_run(c2, 1'b0, 8, exp_n);
      push(40'(c), c2 ? 16 : 8);
    end
    @(negedge clk);
    addr = a; aw = 3'(awb); len = 6'(ln); no_ack = na; crc_en = ce; crc_two = c2;
    dyn = dy; aa = au; retx = rx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(frame_active == 1'b1, "R1", {name, " frame_active after start"}, int'(frame_active), 1);
    if (disturb) begin
      addr = ~a; aw = 3'd3; len = 6'd2; dyn = ~dy; aa = ~au; crc_two = ~c2; no_ack = ~na;
    end
    got_n = 0; src_idx = 0; gapc = gap; tickc = 0; cycles = 0; starved = 1'b0;
    while (frame_active && cycles < 20000) begin
      start    = (disturb && cycles == 3);
      pl_valid = (src_idx < ln) && (gapc == 0);
      pl_data  = pay_mem[src_idx % 32];
      tx_ready = (tickc == 0);
      if (tx_valid && tx_ready && got_n < 512) begin
        got_b[got_n] = tx_bit;
        got_n++;
      end
      if (!tx_valid) starved = 1'b1;
      pl_x = pl_valid && pl_ready;
      @(negedge clk);
      if (pl_x) begin src_idx++; gapc = gap; end
      else if (gapc > 0) gapc--;
      tickc = (tickc + 1) % tper;
      cycles++;
    end
    start = 1'b0; pl_valid = 1'b0; tx_ready = 1'b0;
    chk(got_n == exp_n, "R9 R11", {name, " bit count"}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      if (got_b[i] != exp_b[i]) begin
        string rq;
        if (i < 8)             rq = "R2";
        else if (i < addr_end) rq = "R3";
        else if (i < ctrl_end) rq = "R4";
        else if (i < pay_end)  rq = "R6";
        else                   rq = c2 ? "R8" : "R7";
        chk(1'b0, rq, $sformatf("%s bit %0d", name, i), int'(got_b[i]), int'(exp_b[i]));
        break;
      end
    end
    chk(src_idx == ln, "R6", {name, " payload bytes taken"}, src_idx, ln);
    if (ctrl_on && got_n >= ctrl_end)
      chk({got_b[addr_end+6], got_b[addr_end+7]} == 2'(exp_pid), "R5",
          {name, " packet id"}, int'({got_b[addr_end+6], got_b[addr_end+7]}), exp_pid);
    if (crc_on && got_n == exp_n) begin
      c = crc_run(c2, 1'b1, 8, got_n);
      chk(c == 16'h0, c2 ? "R8" : "R7", {name, " receiver CRC remainder"}, int'(c), 0);
    end
    if (gap > 20) chk(starved, "R10", {name, " underrun paused output"}, int'(starved), 1);
    chk(!tx_valid && !pl_ready, "R11", {name, " idle after frame"},
        int'({tx_valid, pl_ready}), 0);
  endtask

  task automatic try_reject(input int awb, input int ln, input string name);
    bit seen = 1'b0;
    @(negedge clk);
    aw = 3'(awb); len = 6'(ln); retx = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 5; i++) begin
      if (frame_active || pl_ready) seen = 1'b1;
      @(negedge clk);
    end
    chk(!seen, "R1", {name, " start ignored"}, int'(seen), 0);
  endtask

  task automatic test_reset;
    chk(!frame_active && !tx_valid && !pl_ready, "R1", "reset outputs idle",
        int'({frame_active, tx_valid, pl_ready}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    // R3 R4 plain frame, no control word, no CRC
    run_frame(40'hA1B2C3D4E5, 5, 4, 0, 0, 0, 0, 0, 0, 0, 1, 0, "plain");
    // R7 1-byte CRC, 3-byte address starting with 0
    run_frame(40'h00003C5A71, 3, 1, 0, 1, 0, 0, 0, 0, 0, 3, 0, "crc8");
    // R8 R9 CRC forced by auto-ack, full length
    run_frame(40'h00E7E7E7E7, 4, 32, 0, 0, 1, 0, 1, 0, 0, 2, 0, "aa_crc16");
    // R4 R9 dynamic length with no-ack
    run_frame(40'h3355AACC0F, 5, 17, 1, 0, 0, 1, 0, 0, 0, 7, 0, "dyn_noack");
    // R5 retransmission keeps the identifier
    run_frame(40'hC2C2C2C2C2, 5, 5, 0, 1, 1, 1, 0, 1, 0, 2, 0, "retx");
    // R5 identifier wraps
    for (int k = 0; k < 4; k++)
      run_frame(40'h8100FF0055, 5, 2, 0, 0, 0, 0, 1, 0, 0, 1, 0, "pid_wrap");
    // R10 payload underrun
    run_frame(40'h123456789A, 5, 6, 0, 1, 1, 0, 1, 0, 40, 2, 0, "underrun");
    // R11 R1 mid-frame changes and start ignored
    run_frame(40'hF0F0F01234, 5, 3, 0, 1, 0, 1, 0, 0, 0, 2, 1, "disturb");
    run_frame(40'h0102030405, 5, 2, 0, 0, 0, 1, 0, 0, 0, 1, 0, "after_disturb");
    try_reject(5, 0,  "len0");
    try_reject(5, 33, "len33");
    try_reject(2, 4,  "aw2");
    try_reject(6, 4,  "aw6");
    // R5 rejected starts left the identifier alone
    run_frame(40'h5555AAAA11, 4, 1, 0, 0, 0, 0, 1, 0, 0, 1, 0, "after_reject");
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule